// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches sixteen external input lines and turns their transitions into interrupt requests and event pulses. Each line can be fed from one of several input ports: for a given line number, a small selector field chooses which port's pin of that number drives it. The selected pin passes through a two-flop synchroniser. Each line then compares the synchronised level with its level one cycle earlier to find rising and falling transitions. Each line can be set to react to rising transitions, falling transitions or both. A rising transition and a falling transition set two separate pending flags, so software can tell which one occurred.

Each line has its own interrupt mask and its own event mask. The interrupt output of a line stays high while either of its pending flags is set and its interrupt mask is set. The event output gives a one-cycle pulse on each accepted transition when the event mask is set. Software can raise a line directly. Software clears pending flags by writing ones.

Configuration goes through a simple word-addressed register bus. Each access carries a privilege qualifier and a security qualifier. Each line has a privilege attribute and a security attribute, both lockable. Once a line is marked privileged, unprivileged accesses can neither change that line's configuration nor see it.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` and `evt` are low. This covers enables, masks, pending flags, selectors, attributes and lock.
- R2: Register 0 holds the per-line rising enables and register 1 the per-line falling enables, with bit n belonging to line n. A line with only its rising enable set flags only low-to-high transitions. A line with only its falling enable set flags only high-to-low transitions. A line with both set flags both. A line with neither flags nothing.
- R3: Register 5 holds the rising-pending flags and register 6 the falling-pending flags. Each flag is set by its own transition direction. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R4: Register 2 is the interrupt mask. `irq[n]` is high exactly when line n has at least one pending flag set and mask bit n is set. A mask change is visible on the cycle after the write.
- R5: Register 3 is the event mask. An accepted transition on line n with event mask bit n set makes `evt[n]` high for exactly one cycle. That cycle follows the third rising clock edge after the pin changes. With the event mask bit clear, no pulse appears.
- R6: Writing 1 to bit n of register 4 sets line n's rising-pending flag in the same clock edge and counts as an accepted transition for the event output. Register 4 always reads 0.
- R7: Registers 10 to 13 select the source port. Line n uses register 10 + n/4, bits [8*(n%4)+1 : 8*(n%4)], and port p's pin for line n is `pin_in[p*16+n]`.
- R8: Register 7 holds the privilege attributes and can only be written by a privileged access. For a line whose privilege bit is set, unprivileged writes leave that line's bits unchanged in registers 0 to 6 and 10 to 13, and unprivileged reads return 0 for those bits.
- R9: Register 8 holds the security attributes and can only be written by a secure access. Writes without the secure qualifier are ignored.
- R10: Bit 0 of register 9 is the lock. It is set by a privileged write of 1, is never cleared except by reset, and while it is set all writes to registers 7 and 8 are ignored.
- R11: Read data appears on `rd_data` in the cycle after the read request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 64 | External pins, port p line n at bit p*16+n |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Word register index |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Access is privileged |
| req_secure | input | 1 | Access is secure |
| rd_data | output | 32 | Read data, registered |
| irq | output | 16 | Per-line interrupt requests |
| evt | output | 16 | Per-line event pulses |

## Verification
The main edge path is driven from a vector table. In each vector the selected port makes one transition while the unselected ports make the opposite transition. A wrong selector decode therefore shows up as the wrong pending flag rather than as no flag. The vectors combine each enable setting with rising, falling and static pins, which separates direction detection from the enable gating. Directed tests then step through masking, write-one-to-clear, event pulse width and timing, software triggering, unprivileged access to privileged lines, and writes to the attribute registers without the secure qualifier and after lock.

// File: rtl/edge_irq_pkg.sv
// Package: shared register indices and layout constants for the edge
// interrupt controller. Assumes a word-addressed register bus.
package edge_irq_pkg;
    localparam int A_RISE_EN   = 0;
    localparam int A_FALL_EN   = 1;
    localparam int A_IRQ_MASK  = 2;
    localparam int A_EVT_MASK  = 3;
    localparam int A_SW_TRIG   = 4;
    localparam int A_RISE_PEND = 5;
    localparam int A_FALL_PEND = 6;
    localparam int A_PRIV      = 7;
    localparam int A_SEC       = 8;
    localparam int A_LOCK      = 9;
    localparam int A_SEL_BASE  = 10;

    // Selector packing: four lines per register, one byte lane per line.
    localparam int LINES_PER_SEL = 4;
    localparam int FIELD_W       = 8;
endpackage

// File: rtl/edge_irq_line.sv
// Module: one line of the controller. Synchronises the selected pin,
// detects qualified transitions, holds the rising and falling pending
// flags and forms the one-cycle event pulse.
// Assumes clr_* and sw_set are single-cycle strobes from the register block.
module edge_irq_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic rise_en,
    input  logic fall_en,
    input  logic evt_en,
    input  logic sw_set,
    input  logic clr_rise,
    input  logic clr_fall,
    output logic rise_pend,
    output logic fall_pend,
    output logic evt_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic                   rise_hit;
    logic                   fall_hit;

    assign level    = sync_q[SYNC_STAGES-1];
    assign rise_hit = rise_en &  level & ~prev_q;
    assign fall_hit = fall_en & ~level &  prev_q;

    // Synchroniser chain plus previous-level register for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            prev_q <= level;
        end
    end

    // Pending flags: a new set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_pend <= 1'b0;
            fall_pend <= 1'b0;
        end else begin
            rise_pend <= (rise_pend & ~clr_rise) | rise_hit | sw_set;
            fall_pend <= (fall_pend & ~clr_fall) | fall_hit;
        end
    end

    // Event pulse: one cycle per accepted transition when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
        end else begin
            evt_pulse <= evt_en & (rise_hit | fall_hit | sw_set);
        end
    end
endmodule

// File: rtl/edge_irq_regs.sv
// Module: register file and bus decode. Holds enables, masks, port
// selectors and lockable attributes, applies per-line privilege filtering
// to writes and reads, and produces trigger and clear strobes.
// Assumes DATA_W >= NUM_LINES and LINES_PER_SEL*FIELD_W <= DATA_W.
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic                       req_priv,
    input  logic                       req_secure,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_LINES-1:0]       rise_pend,
    input  logic [NUM_LINES-1:0]       fall_pend,
    output logic [NUM_LINES-1:0]       rise_en,
    output logic [NUM_LINES-1:0]       fall_en,
    output logic [NUM_LINES-1:0]       irq_mask,
    output logic [NUM_LINES-1:0]       evt_mask,
    output logic [NUM_LINES-1:0]       sw_set,
    output logic [NUM_LINES-1:0]       clr_rise,
    output logic [NUM_LINES-1:0]       clr_fall,
    output logic [NUM_LINES-1:0]       priv_attr,
    output logic [NUM_LINES-1:0]       sec_attr,
    output logic                       lock,
    output logic [NUM_LINES*SEL_W-1:0] sel_flat
);
    localparam int SEL_REGS = (NUM_LINES + LINES_PER_SEL - 1) / LINES_PER_SEL;

    logic                           wr_en;
    logic                           rd_en;
    logic [NUM_LINES-1:0]           access_ok;
    logic [NUM_LINES-1:0]           wr_lines;
    logic [DATA_W-1:0]              rd_next;
    logic [SEL_REGS-1:0][DATA_W-1:0] sel_words;
    logic                           unused_wdata;

    assign wr_en        = req_valid &  req_write;
    assign rd_en        = req_valid & ~req_write;
    assign access_ok    = req_priv ? '1 : ~priv_attr;
    assign wr_lines     = req_wdata[NUM_LINES-1:0] & access_ok;
    assign unused_wdata = ^req_wdata;

    // Strobes for software trigger and write-one-to-clear of pending flags.
    assign sw_set   = (wr_en && req_addr == ADDR_W'(A_SW_TRIG))   ? wr_lines : '0;
    assign clr_rise = (wr_en && req_addr == ADDR_W'(A_RISE_PEND)) ? wr_lines : '0;
    assign clr_fall = (wr_en && req_addr == ADDR_W'(A_FALL_PEND)) ? wr_lines : '0;

    // Per-line configuration registers with privileged bits protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en  <= '0;
            fall_en  <= '0;
            irq_mask <= '0;
            evt_mask <= '0;
        end else if (wr_en) begin
            if (req_addr == ADDR_W'(A_RISE_EN))  rise_en  <= (rise_en  & ~access_ok) | wr_lines;
            if (req_addr == ADDR_W'(A_FALL_EN))  fall_en  <= (fall_en  & ~access_ok) | wr_lines;
            if (req_addr == ADDR_W'(A_IRQ_MASK)) irq_mask <= (irq_mask & ~access_ok) | wr_lines;
            if (req_addr == ADDR_W'(A_EVT_MASK)) evt_mask <= (evt_mask & ~access_ok) | wr_lines;
        end
    end

    // Attribute registers and the sticky lock that freezes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_attr <= '0;
            sec_attr  <= '0;
            lock      <= 1'b0;
        end else if (wr_en && !lock) begin
            if (req_addr == ADDR_W'(A_PRIV) && req_priv)
                priv_attr <= req_wdata[NUM_LINES-1:0];
            if (req_addr == ADDR_W'(A_SEC) && req_secure)
                sec_attr <= req_wdata[NUM_LINES-1:0];
            if (req_addr == ADDR_W'(A_LOCK) && req_priv && req_wdata[0])
                lock <= 1'b1;
        end
    end

    // One selector register per line, packed four to a bus word.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_sel
        localparam int REG_IDX = A_SEL_BASE + l / LINES_PER_SEL;
        localparam int LSB     = (l % LINES_PER_SEL) * FIELD_W;
        logic [SEL_W-1:0] sel_r;

        // Selector update, gated by this line's privilege.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r <= '0;
            end else if (wr_en && req_addr == ADDR_W'(REG_IDX) && access_ok[l]) begin
                sel_r <= req_wdata[LSB +: SEL_W];
            end
        end
        assign sel_flat[l*SEL_W +: SEL_W] = sel_r;
    end

    // Read mux with per-line visibility filtering.
    always_comb begin
        sel_words = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (access_ok[l])
                sel_words[l / LINES_PER_SEL][(l % LINES_PER_SEL) * FIELD_W +: SEL_W] =
                    sel_flat[l*SEL_W +: SEL_W];
        end
        rd_next = '0;
        case (int'(req_addr))
            A_RISE_EN:   rd_next[NUM_LINES-1:0] = rise_en   & access_ok;
            A_FALL_EN:   rd_next[NUM_LINES-1:0] = fall_en   & access_ok;
            A_IRQ_MASK:  rd_next[NUM_LINES-1:0] = irq_mask  & access_ok;
            A_EVT_MASK:  rd_next[NUM_LINES-1:0] = evt_mask  & access_ok;
            A_RISE_PEND: rd_next[NUM_LINES-1:0] = rise_pend & access_ok;
            A_FALL_PEND: rd_next[NUM_LINES-1:0] = fall_pend & access_ok;
            A_PRIV:      rd_next[NUM_LINES-1:0] = priv_attr;
            A_SEC:       rd_next[NUM_LINES-1:0] = sec_attr;
            A_LOCK:      rd_next[0]             = lock;
            default: begin
                for (int r = 0; r < SEL_REGS; r++) begin
                    if (int'(req_addr) == A_SEL_BASE + r) rd_next = sel_words[r];
                end
            end
        endcase
    end

    // Registered read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_next : '0;
        end
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: top of the external interrupt edge controller. Picks each line's
// source port, instantiates one detection slice per line and combines the
// pending flags with the interrupt mask.
// Assumes pin_in is asynchronous; port p pin n sits at bit p*NUM_LINES+n.
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int NUM_PORTS   = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    input  logic                           req_priv,
    input  logic                           req_secure,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NUM_LINES-1:0]           irq,
    output logic [NUM_LINES-1:0]           evt
);
    localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_LINES-1:0]       rise_en_w, fall_en_w, irq_mask_w, evt_mask_w;
    logic [NUM_LINES-1:0]       sw_set_w, clr_rise_w, clr_fall_w;
    logic [NUM_LINES-1:0]       priv_attr_w, sec_attr_w;
    logic                       lock_w;
    logic [NUM_LINES*SEL_W-1:0] sel_flat_w;
    logic [NUM_LINES-1:0]       sel_pin;
    logic [NUM_LINES-1:0]       rise_pend, fall_pend;
    logic                       unused_attr;

    assign unused_attr = ^{priv_attr_w, sec_attr_w, lock_w};

    edge_irq_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_priv   (req_priv),
        .req_secure (req_secure),
        .rd_data    (rd_data),
        .rise_pend  (rise_pend),
        .fall_pend  (fall_pend),
        .rise_en    (rise_en_w),
        .fall_en    (fall_en_w),
        .irq_mask   (irq_mask_w),
        .evt_mask   (evt_mask_w),
        .sw_set     (sw_set_w),
        .clr_rise   (clr_rise_w),
        .clr_fall   (clr_fall_w),
        .priv_attr  (priv_attr_w),
        .sec_attr   (sec_attr_w),
        .lock       (lock_w),
        .sel_flat   (sel_flat_w)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        // Source port multiplexer for this line number.
        always_comb begin
            sel_pin[l] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel_flat_w[l*SEL_W +: SEL_W] == SEL_W'(p))
                    sel_pin[l] = pin_in[p*NUM_LINES + l];
            end
        end

        edge_irq_line #(
            .SYNC_STAGES (SYNC_STAGES)
        ) i_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_raw   (sel_pin[l]),
            .rise_en   (rise_en_w[l]),
            .fall_en   (fall_en_w[l]),
            .evt_en    (evt_mask_w[l]),
            .sw_set    (sw_set_w[l]),
            .clr_rise  (clr_rise_w[l]),
            .clr_fall  (clr_fall_w[l]),
            .rise_pend (rise_pend[l]),
            .fall_pend (fall_pend[l]),
            .evt_pulse (evt[l])
        );
    end

    assign irq = (rise_pend | fall_pend) & irq_mask_w;
endmodule

// File: rtl/edge_irq_checker.sv
// Module: property checker for the edge interrupt controller, bound to
// the top. Watches pending persistence, lock stickiness, attribute
// freezing and output qualification.
module edge_irq_checker
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [DATA_W-1:0]    req_wdata,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_LINES-1:0] evt,
    input logic [NUM_LINES-1:0] rise_pend,
    input logic [NUM_LINES-1:0] fall_pend,
    input logic [NUM_LINES-1:0] evt_mask,
    input logic [NUM_LINES-1:0] priv_attr,
    input logic [NUM_LINES-1:0] sec_attr,
    input logic                 lock
);
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    assert_attr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(priv_attr) && $stable(sec_attr)));

    assert_evt_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~$past(evt_mask)) == '0);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
        assert_rise_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_pend[l] && !(req_valid && req_write &&
                req_addr == ADDR_W'(A_RISE_PEND) && req_wdata[l])) |=> rise_pend[l]);

        assert_fall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (fall_pend[l] && !(req_valid && req_write &&
                req_addr == ADDR_W'(A_FALL_PEND) && req_wdata[l])) |=> fall_pend[l]);

        assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq[l] |-> (rise_pend[l] || fall_pend[l]));
    end
endmodule

bind edge_irq_ctrl edge_irq_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .irq       (irq),
    .evt       (evt),
    .rise_pend (rise_pend),
    .fall_pend (fall_pend),
    .evt_mask  (evt_mask_w),
    .priv_attr (priv_attr_w),
    .sec_attr  (sec_attr_w),
    .lock      (lock_w)
);

// File: tb/test_edge_irq_ctrl.sv
// Bench: table-driven edge and port-select checks, then directed tests.
module test_edge_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int L = 5;

    typedef struct packed {
        logic       re;
        logic       fe;
        logic [1:0] port;
        logic       v0;
        logic       v1;
        logic       exp_r;
        logic       exp_f;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pin_in = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_priv = 1'b1;
    logic        req_secure = 1'b1;
    logic [31:0] rd_data;
    logic [15:0] irq;
    logic [15:0] evt;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_ctrl i_edge_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_priv   (req_priv),
        .req_secure (req_secure),
        .rd_data    (rd_data),
        .irq        (irq),
        .evt        (evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d,
                          input logic pv = 1'b1, input logic sc = 1'b1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'(a);
        req_wdata = d; req_priv = pv; req_secure = sc;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b1; req_secure = 1'b1;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d,
                          input logic pv = 1'b1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'(a); req_priv = pv;
        @(posedge clk); @(negedge clk);
        d = rd_data;
        req_valid = 1'b0; req_priv = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Selected port drives val on line L; the other ports drive the inverse.
    task automatic set_pins(input int port, input logic val);
        for (int p = 0; p < 4; p++) pin_in[p*16 + L] = (p == port) ? val : ~val;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int at;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state of every register and both outputs
        for (int a = 0; a < 14; a++) begin
            bus_rd(a, rv);
            check($sformatf("R1 reg %0d", a), rv, 32'h0);
        end
        check("R1 irq", {16'h0, irq}, 32'h0);
        check("R1 evt", {16'h0, evt}, 32'h0);

        // R2 R3 R7: table of enable / port / transition vectors on line L
        foreach (VECS[i]) begin
            bus_wr(0, 32'(VECS[i].re) << L);
            bus_wr(1, 32'(VECS[i].fe) << L);
            bus_wr(11, 32'(VECS[i].port) << 8);
            set_pins(VECS[i].port, VECS[i].v0);
            wait_cyc(5);
            bus_wr(5, 32'hFFFF_FFFF);
            bus_wr(6, 32'hFFFF_FFFF);
            set_pins(VECS[i].port, VECS[i].v1);
            wait_cyc(5);
            bus_rd(5, rv);
            check($sformatf("R2 R7 vec %0d rise pend", i), rv, 32'(VECS[i].exp_r) << L);
            bus_rd(6, rv);
            check($sformatf("R2 R3 vec %0d fall pend", i), rv, 32'(VECS[i].exp_f) << L);
        end

        // R4: interrupt masking
        bus_wr(0, 32'h1 << L);
        bus_wr(1, 32'h0);
        bus_wr(11, 32'h0);
        set_pins(0, 1'b0);
        wait_cyc(5);
        bus_wr(5, 32'hFFFF_FFFF);
        bus_wr(6, 32'hFFFF_FFFF);
        set_pins(0, 1'b1);
        wait_cyc(5);
        check("R4 masked irq", {16'h0, irq}, 32'h0);
        bus_wr(2, 32'h1 << L);
        check("R4 unmasked irq", {16'h0, irq}, 32'h1 << L);

        // R3: write 0 keeps the flag, write 1 clears it
        bus_wr(5, 32'h0);
        bus_rd(5, rv);
        check("R3 write zero keeps", rv, 32'h1 << L);
        bus_wr(5, 32'h1 << L);
        bus_rd(5, rv);
        check("R3 write one clears", rv, 32'h0);
        bus_wr(2, 32'h0);
        check("R4 mask cleared irq", {16'h0, irq}, 32'h0);

        // R5: event pulse width and timing
        bus_wr(3, 32'h1 << L);
        set_pins(0, 1'b0);
        wait_cyc(5);
        cnt = 0; at = 0;
        set_pins(0, 1'b1);
        for (int c = 1; c <= 8; c++) begin
            @(posedge clk); @(negedge clk);
            if (evt[L]) begin cnt++; at = c; end
        end
        check("R5 pulse count", 32'(cnt), 32'd1);
        check("R5 pulse cycle", 32'(at), 32'd3);
        bus_wr(3, 32'h0);
        set_pins(0, 1'b0);
        wait_cyc(5);
        cnt = 0;
        set_pins(0, 1'b1);
        for (int c = 1; c <= 8; c++) begin
            @(posedge clk); @(negedge clk);
            if (evt[L]) cnt++;
        end
        check("R5 masked no pulse", 32'(cnt), 32'd0);

        // R6: software trigger sets rising pending; register reads 0
        bus_wr(5, 32'hFFFF_FFFF);
        bus_wr(6, 32'hFFFF_FFFF);
        bus_wr(2, 32'h1 << 9);
        bus_wr(3, 32'h1 << 9);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd4; req_wdata = 32'h1 << 9;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R6 sw irq", {16'h0, irq}, 32'h1 << 9);
        check("R6 sw event", {16'h0, evt}, 32'h1 << 9);
        bus_rd(5, rv);
        check("R6 sw rise pend", rv, 32'h1 << 9);
        bus_rd(4, rv);
        check("R6 R11 trigger reads zero", rv, 32'h0);
        bus_wr(3, 32'h0);

        // R8: privilege filtering
        bus_wr(7, 32'h1 << 2, 1'b0);
        bus_rd(7, rv);
        check("R8 unpriv attr write ignored", rv, 32'h0);
        bus_wr(7, 32'h1 << 2);
        bus_rd(7, rv);
        check("R8 priv attr write", rv, 32'h1 << 2);
        bus_wr(1, 32'hFFFF_FFFF, 1'b0);
        bus_rd(1, rv);
        check("R8 unpriv write skips line 2", rv, 32'h0000_FFFB);
        bus_wr(1, 32'hFFFF_FFFF);
        bus_rd(1, rv, 1'b0);
        check("R8 unpriv read hides line 2", rv, 32'h0000_FFFB);
        bus_rd(1, rv);
        check("R8 priv read sees line 2", rv, 32'h0000_FFFF);
        bus_wr(1, 32'h0);

        // R9: security attribute needs a secure access
        bus_wr(8, 32'h0000_00FF, 1'b1, 1'b0);
        bus_rd(8, rv);
        check("R9 nonsecure write ignored", rv, 32'h0);
        bus_wr(8, 32'h0000_0030);
        bus_rd(8, rv);
        check("R9 secure write", rv, 32'h0000_0030);

        // R10: lock behaviour
        bus_wr(9, 32'h1, 1'b0);
        bus_rd(9, rv);
        check("R10 unpriv lock ignored", rv, 32'h0);
        bus_wr(9, 32'h1);
        bus_rd(9, rv);
        check("R10 lock set", rv, 32'h1);
        bus_wr(7, 32'h0);
        bus_rd(7, rv);
        check("R10 priv attr frozen", rv, 32'h1 << 2);
        bus_wr(8, 32'h0);
        bus_rd(8, rv);
        check("R10 sec attr frozen", rv, 32'h0000_0030);
        bus_wr(9, 32'h0);
        bus_rd(9, rv);
        check("R10 lock sticky", rv, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule